// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers asynchronous serial frames from a single receive line. An external baud generator supplies a sub-bit strobe (`os_tick`). The receiver counts that strobe to find the middle of every bit. The strobe ratio per bit can be 16, 8, 6 or 4, or oversampling can be switched off, in which case one strobe marks one bit. In the 16x, 8x and 6x ratios, each bit can be decided by a three-sample majority vote around the bit centre instead of by a single sample.

Each completed frame is written into a small first-word-fall-through queue, together with a parity-error flag and a framing-error flag. The frame has 7, 8 or 9 data bits, optional even or odd parity, and a stop bit. The consumer pops frames with `rd_en`. The consumer sees the fill count, an empty flag, a watermark level flag and a one-cycle underflow pulse.

A blocking mode discards every incoming frame until a frame equal to a programmed start value arrives. That matching frame is kept and ends the blocking. The receive line can be inverted ahead of all receive logic.

Top module: `uart_ovs_rx`

## Requirements
- R1: `cfg_ovs` selects the number of `os_tick` strobes per bit: 0 = 16, 1 = 8, 2 = 6, 3 = 4, 4 = oversampling off (1 strobe per bit). Codes 5 to 7 act as 16.
- R2: The strobe at which the line is first seen low is strobe 0 of the start bit. Each bit is decided at strobe N/2 of that bit, where N is the ratio. With oversampling off, every strobe decides one bit.
- R3: With `cfg_vote_en` = 1 and ratio 16, 8 or 6, a bit takes the majority of the samples at strobes N/2-1, N/2 and N/2+1, so a single wrong sample at N/2 has no effect. With the vote off, or at ratio 4 or with oversampling off, the single sample at N/2 decides the bit.
- R4: If the start bit reads high at its decision point, the receiver returns to idle and writes nothing.
- R5: `cfg_dbits` 0/1/2 (3 acts as 2) selects 7/8/9 data bits, sent LSB first. `cfg_par` 0 = none, 1 = even, 2 = odd (3 = none); the parity bit follows the data. Data is stored right-aligned, with unused upper bits zero.
- R6: The framing-error flag is stored as 1 when the stop bit decides low. The parity-error flag is stored as 1 when the data bits and the parity bit fail the selected parity.
- R7: With `cfg_inv` = 1, the receive line is inverted before any receive logic.
- R8: The queue holds up to 4 frames in arrival order. `rd_data` shows the oldest frame and `rd_en` removes it. A frame that completes while the queue is full is dropped.
- R9: `rx_level` is 1 exactly when `rx_count` is at least `cfg_wm` + 1.
- R10: `rd_en` while the queue is empty raises `rx_uflow` for the next cycle only and leaves the count unchanged.
- R11: A pulse on `blk_set` enters blocking mode and a pulse on `blk_clr` leaves it; `blk_set` wins. While blocked, completed frames are discarded.
- R12: While blocked, a frame whose data equals a nonzero `cfg_sframe` is written to the queue and ends blocking. With `cfg_sframe` = 0, no frame ends blocking.
- R13: With oversampling off, `os_tick` is high on at most one of any three consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Sub-bit sampling strobe |
| rx_pin | input | 1 | Serial receive line, idle high |
| cfg_ovs | input | 3 | Strobes-per-bit code (R1) |
| cfg_vote_en | input | 1 | Majority vote enable |
| cfg_inv | input | 1 | Invert receive line |
| cfg_dbits | input | 2 | Data bit count code |
| cfg_par | input | 2 | Parity mode code |
| cfg_sframe | input | 9 | Start frame value that ends blocking, 0 = feature off |
| blk_set | input | 1 | Enter blocking mode (pulse) |
| blk_clr | input | 1 | Leave blocking mode (pulse) |
| cfg_wm | input | 2 | Watermark, level at count >= cfg_wm + 1 |
| rd_en | input | 1 | Pop the oldest frame |
| rd_data | output | 9 | Oldest frame data |
| rd_perr | output | 1 | Parity error flag of oldest frame |
| rd_ferr | output | 1 | Framing error flag of oldest frame |
| rx_empty | output | 1 | Queue empty |
| rx_count | output | 3 | Frames held |
| rx_level | output | 1 | Watermark level reached |
| rx_uflow | output | 1 | Read-while-empty pulse |
| rx_blocked | output | 1 | Blocking mode active |

## Verification
The failures that matter are a phase counter or bit index that drifts. Such a drift does not stall the receiver. Instead, the next stored frame holds shifted data bits, a wrong parity flag or a false framing error, and `rd_data` shows this as soon as the frame is popped. Spurious starts after a low stop bit or a short start glitch show up as extra or missing queue entries in `rx_count` within one frame time. A blocking register stuck in the wrong state shows up at once in `rx_blocked` and in whether the next frame lands in the queue.

// File: rtl/uart_ovs_rx_pkg.sv
package uart_ovs_rx_pkg;

   localparam int unsigned DBITS_MAX = 9;

   typedef enum logic [2:0] {
      OVS_16  = 3'd0,
      OVS_8   = 3'd1,
      OVS_6   = 3'd2,
      OVS_4   = 3'd3,
      OVS_OFF = 3'd4
   } ovs_e;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2
   } par_e;

   typedef struct packed {
      logic                 perr;
      logic                 ferr;
      logic [DBITS_MAX-1:0] data;
   } rx_word_t;

   // strobes per bit for a ratio code
   function automatic logic [4:0] ovs_ratio(input logic [2:0] m);
      case (m)
         OVS_8:   return 5'd8;
         OVS_6:   return 5'd6;
         OVS_4:   return 5'd4;
         OVS_OFF: return 5'd1;
         default: return 5'd16;
      endcase
   endfunction

   function automatic logic ovs_can_vote(input logic [2:0] m);
      return (m == OVS_16) || (m == OVS_8) || (m == OVS_6);
   endfunction

endpackage

// File: rtl/uart_ovs_rx_sync.sv
module uart_ovs_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic inv,
   output logic line
);

   logic raw;
   assign raw = pin ^ inv;   // polarity applied ahead of the receiver

   if (STAGES == 0) begin : g_direct
      assign line = raw;
   end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '1;
         else        q <= {q[STAGES-2+1-1:0], raw};
      end
      assign line = q[STAGES-1];
   end

endmodule

// File: rtl/uart_ovs_rx_frame.sv
module uart_ovs_rx_frame
   import uart_ovs_rx_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 line,
   input  logic [2:0]           ovs,
   input  logic                 vote_en,
   input  logic [1:0]           dbits,
   input  logic [1:0]           par,
   input  logic [DBITS_MAX-1:0] sframe,
   input  logic                 blk_set,
   input  logic                 blk_clr,
   output logic                 push,
   output rx_word_t             word,
   output logic                 blocked
);

   localparam int unsigned PH_W = 5;
   localparam int unsigned BI_W = 4;

   logic [PH_W-1:0]      ratio, mid, eval_ph, ph;
   logic [BI_W-1:0]      ndata, stop_idx, bidx;
   logic                 voting, has_par, odd_par, busy, parbit, done, smp, match;
   logic [1:0]           hist;
   logic [DBITS_MAX-1:0] shreg;

   always_comb begin
      ratio   = ovs_ratio(ovs);
      mid     = ratio >> 1;
      voting  = vote_en && ovs_can_vote(ovs);
      eval_ph = mid + {{(PH_W-1){1'b0}}, voting};
      case (dbits)
         2'd0:    ndata = 4'd7;
         2'd1:    ndata = 4'd8;
         default: ndata = 4'd9;
      endcase
      has_par  = (par == PAR_EVEN) || (par == PAR_ODD);
      odd_par  = (par == PAR_ODD);
      stop_idx = ndata + 4'd1 + {3'd0, has_par};
      // majority of the samples at mid-1, mid and mid+1
      smp = voting ? ((hist[1] & hist[0]) | (hist[1] & line) | (hist[0] & line)) : line;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         ph     <= '0;
         bidx   <= '0;
         shreg  <= '0;
         parbit <= 1'b0;
         hist   <= 2'b11;
         done   <= 1'b0;
         word   <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            hist <= {hist[0], line};
            if (!busy) begin
               if (!line) begin
                  busy  <= 1'b1;
                  shreg <= '0;
                  if (ratio == 5'd1) begin
                     ph   <= '0;
                     bidx <= 4'd1;
                  end else begin
                     ph   <= 5'd1;
                     bidx <= '0;
                  end
               end
            end else begin
               if (ph == ratio - 5'd1) begin
                  ph   <= '0;
                  bidx <= bidx + 4'd1;
               end else begin
                  ph <= ph + 5'd1;
               end
               if (ph == eval_ph) begin
                  if (bidx == '0) begin
                     if (smp) busy <= 1'b0;          // start glitch
                  end else if (bidx <= ndata) begin
                     shreg[bidx - 4'd1] <= smp;
                  end else if (has_par && (bidx == ndata + 4'd1)) begin
                     parbit <= smp;
                  end
                  if (bidx == stop_idx) begin
                     busy      <= 1'b0;
                     done      <= 1'b1;
                     word.data <= shreg;
                     word.ferr <= !smp;
                     word.perr <= has_par & (^shreg ^ parbit ^ odd_par);
                  end
               end
            end
         end
      end
   end

   assign match = (sframe != '0) && (word.data == sframe);
   assign push  = done && (!blocked || match);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              blocked <= 1'b0;
      else if (blk_set)        blocked <= 1'b1;
      else if (blk_clr)        blocked <= 1'b0;
      else if (done && match)  blocked <= 1'b0;
   end

endmodule

// File: rtl/uart_ovs_rx_fifo.sv
module uart_ovs_rx_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 11
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [W-1:0]                   wdata,
   input  logic                           pop,
   input  logic [$clog2(DEPTH)-1:0]       wm,
   output logic [W-1:0]                   rdata,
   output logic [$clog2(DEPTH+1)-1:0]     count,
   output logic                           empty,
   output logic                           level,
   output logic                           uflow
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          wr, rd;

   assign wr    = push && (count != CW'(DEPTH));
   assign rd    = pop && (count != '0);
   assign rdata = mem[rptr];
   assign empty = (count == '0);
   assign level = (count > CW'(wm));

   always_ff @(posedge clk) begin
      if (wr) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         uflow <= 1'b0;
      end else begin
         if (wr) wptr <= wptr + 1'b1;
         if (rd) rptr <= rptr + 1'b1;
         count <= count + CW'(wr) - CW'(rd);
         uflow <= pop && (count == '0);
      end
   end

endmodule

// File: rtl/uart_ovs_rx.sv
module uart_ovs_rx
   import uart_ovs_rx_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH  = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            os_tick,
   input  logic                            rx_pin,
   input  logic [2:0]                      cfg_ovs,
   input  logic                            cfg_vote_en,
   input  logic                            cfg_inv,
   input  logic [1:0]                      cfg_dbits,
   input  logic [1:0]                      cfg_par,
   input  logic [DBITS_MAX-1:0]            cfg_sframe,
   input  logic                            blk_set,
   input  logic                            blk_clr,
   input  logic [$clog2(FIFO_DEPTH)-1:0]   cfg_wm,
   input  logic                            rd_en,
   output logic [DBITS_MAX-1:0]            rd_data,
   output logic                            rd_perr,
   output logic                            rd_ferr,
   output logic                            rx_empty,
   output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_count,
   output logic                            rx_level,
   output logic                            rx_uflow,
   output logic                            rx_blocked
);

   localparam int unsigned WORD_W = $bits(rx_word_t);

   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 to 4");
   end

   logic        line_s, frm_push;
   rx_word_t    frm_word, head;
   logic [WORD_W-1:0] head_bits;

   uart_ovs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (rx_pin),
      .inv  (cfg_inv),
      .line (line_s)
   );

   uart_ovs_rx_frame u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (os_tick),
      .line   (line_s),
      .ovs    (cfg_ovs),
      .vote_en(cfg_vote_en),
      .dbits  (cfg_dbits),
      .par    (cfg_par),
      .sframe (cfg_sframe),
      .blk_set(blk_set),
      .blk_clr(blk_clr),
      .push   (frm_push),
      .word   (frm_word),
      .blocked(rx_blocked)
   );

   uart_ovs_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (frm_push),
      .wdata(frm_word),
      .pop  (rd_en),
      .wm   (cfg_wm),
      .rdata(head_bits),
      .count(rx_count),
      .empty(rx_empty),
      .level(rx_level),
      .uflow(rx_uflow)
   );

   assign head    = rx_word_t'(head_bits);
   assign rd_data = head.data;
   assign rd_perr = head.perr;
   assign rd_ferr = head.ferr;

endmodule

// File: rtl/uart_ovs_rx_chk.sv
module uart_ovs_rx_chk
   import uart_ovs_rx_pkg::*;
#(
   parameter int unsigned DEPTH = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       os_tick,
   input logic [2:0]                 cfg_ovs,
   input logic                       rd_en,
   input logic                       rx_empty,
   input logic [$clog2(DEPTH+1)-1:0] rx_count,
   input logic                       rx_level,
   input logic                       rx_uflow,
   input logic                       rx_blocked,
   input logic                       blk_set,
   input logic                       blk_clr,
   input logic                       frm_push
);

   localparam int unsigned CW = $clog2(DEPTH + 1);

   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CW'(DEPTH));

   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count != $past(rx_count)) |->
         ((rx_count == $past(rx_count) + 1'b1) || (rx_count + 1'b1 == $past(rx_count))));

   a_r8_push_spaced: assert property (@(posedge clk) disable iff (!rst_n)
      frm_push |=> !frm_push);

   a_r9_full_level: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == CW'(DEPTH)) |-> rx_level);

   a_r10_uflow_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rx_empty) |=> rx_uflow);

   a_r10_uflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rx_uflow |-> ($past(rd_en) && $past(rx_empty)));

   a_r11_set_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      blk_set |=> rx_blocked);

   a_r11_clr_unblocks: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_clr && !blk_set) |=> !rx_blocked);

   a_r13_off_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (os_tick && cfg_ovs == OVS_OFF) |=> !os_tick);

   a_r13_off_tick_gap2: assert property (@(posedge clk) disable iff (!rst_n)
      (os_tick && cfg_ovs == OVS_OFF) |=> ##1 !os_tick);

endmodule

bind uart_ovs_rx uart_ovs_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .os_tick   (os_tick),
   .cfg_ovs   (cfg_ovs),
   .rd_en     (rd_en),
   .rx_empty  (rx_empty),
   .rx_count  (rx_count),
   .rx_level  (rx_level),
   .rx_uflow  (rx_uflow),
   .rx_blocked(rx_blocked),
   .blk_set   (blk_set),
   .blk_clr   (blk_clr),
   .frm_push  (frm_push)
);

// File: tb/sim_uart_ovs_rx.sv
module sim_uart_ovs_rx;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk, rst_n, os_tick, rx_pin;
   logic [2:0] cfg_ovs;
   logic       cfg_vote_en, cfg_inv;
   logic [1:0] cfg_dbits, cfg_par, cfg_wm;
   logic [8:0] cfg_sframe;
   logic       blk_set, blk_clr, rd_en;
   logic [8:0] rd_data;
   logic       rd_perr, rd_ferr, rx_empty, rx_level, rx_uflow, rx_blocked;
   logic [2:0] rx_count;

   int n_chk = 0;
   int n_err = 0;

   uart_ovs_rx u0 (.*);

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int ratio_of(input logic [2:0] m);
      case (m)
         3'd1: return 8;
         3'd2: return 6;
         3'd3: return 4;
         3'd4: return 1;
         default: return 16;
      endcase
   endfunction

   function automatic int eval_of(input logic [2:0] m, input logic v);
      return ratio_of(m) / 2 + ((v && m <= 3'd2) ? 1 : 0);
   endfunction

   // one strobe slot: line set at its start, strobe in its fourth cycle
   task automatic slot(input logic v);
      rx_pin = v ^ cfg_inv;
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
   endtask

   task automatic send(input logic [8:0] d, input int nd, input int par,
                       input bit bad_par, input bit bad_stop, input int gbit, input int gslot);
      logic bits [13];
      int   nb, n, ev;
      logic pb;
      n  = ratio_of(cfg_ovs);
      ev = eval_of(cfg_ovs, cfg_vote_en);
      pb = 1'b0;
      for (int i = 0; i < nd; i++) pb ^= d[i];
      pb = pb ^ (par == 2) ^ bad_par;
      bits[0] = 1'b0;
      for (int i = 0; i < nd; i++) bits[1+i] = d[i];
      nb = 1 + nd;
      if (par == 1 || par == 2) begin bits[nb] = pb; nb++; end
      bits[nb] = 1'b1; nb++;
      for (int i = 0; i < nb; i++) begin
         for (int s = 0; s < n; s++) begin
            logic v;
            v = bits[i];
            if (i == gbit && s == gslot) v = !v;
            if (i == nb - 1 && bad_stop) v = (s <= ev) ? 1'b0 : 1'b1;
            slot(v);
         end
      end
      slot(1'b1);
      slot(1'b1);
   endtask

   function automatic logic [8:0] mask_of(input int nd);
      return 9'((1 << nd) - 1);
   endfunction

   task automatic pop_check(input logic [8:0] ed, input bit ep, input bit ef, input string req);
      chk(!rx_empty, req, rx_empty, 0);
      chk(rd_data == ed, req, rd_data, ed);
      chk(rd_perr == ep, {req, " perr"}, rd_perr, ep);
      chk(rd_ferr == ef, {req, " ferr"}, rd_ferr, ef);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic set_inv(input logic v);
      cfg_inv = v;
      rx_pin  = 1'b1 ^ v;
      slot(1'b1);
      slot(1'b1);
   endtask

   task automatic pulse_blk(input bit set);
      if (set) blk_set = 1'b1; else blk_clr = 1'b1;
      @(negedge clk);
      blk_set = 1'b0;
      blk_clr = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; os_tick = 1'b0; rx_pin = 1'b1;
      cfg_ovs = 3'd0; cfg_vote_en = 1'b0; cfg_inv = 1'b0;
      cfg_dbits = 2'd1; cfg_par = 2'd0; cfg_wm = 2'd3; cfg_sframe = 9'h000;
      blk_set = 1'b0; blk_clr = 1'b0; rd_en = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(rx_empty == 1'b1 && rx_count == 3'd0, "R8 reset empty", rx_count, 0);
      chk(rx_level == 1'b0, "R9 reset level", rx_level, 0);
      chk(rx_blocked == 1'b0, "R11 reset blocked", rx_blocked, 0);
      chk(rx_uflow == 1'b0, "R10 reset uflow", rx_uflow, 0);
      slot(1'b1); slot(1'b1);

      // R1 R2: basic 16x 8N1
      send(9'h0A5, 8, 0, 0, 0, -1, 0);
      pop_check(9'h0A5, 0, 0, "R1 R2 16x frame");

      // R3: glitch on data bit 0 at the centre strobe, vote on
      cfg_vote_en = 1'b1;
      send(9'h0A5, 8, 0, 0, 0, 1, 8);
      pop_check(9'h0A5, 0, 0, "R3 vote masks glitch");
      cfg_vote_en = 1'b0;
      send(9'h0A5, 8, 0, 0, 0, 1, 8);
      pop_check(9'h0A4, 0, 0, "R3 single sample sees glitch");
      cfg_ovs = 3'd3; cfg_vote_en = 1'b1;
      send(9'h0A5, 8, 0, 0, 0, 1, 2);
      pop_check(9'h0A4, 0, 0, "R3 no vote at 4x");
      cfg_vote_en = 1'b0;

      // R4: short start glitch
      cfg_ovs = 3'd0;
      slot(1'b0);
      for (int i = 0; i < 20; i++) slot(1'b1);
      chk(rx_count == 3'd0, "R4 start glitch dropped", rx_count, 0);

      // R6: framing and parity errors; R5 odd parity 7 bits
      send(9'h03C, 8, 0, 0, 1, -1, 0);
      pop_check(9'h03C, 0, 1, "R6 framing error");
      cfg_dbits = 2'd0; cfg_par = 2'd2;
      send(9'h055, 7, 2, 1, 0, -1, 0);
      pop_check(9'h055, 1, 0, "R6 parity error");
      send(9'h155, 7, 2, 0, 0, -1, 0);
      pop_check(9'h055, 0, 0, "R5 7-bit odd parity upper bits zero");

      // R1 R2 R13: oversampling off, one strobe per four clocks
      cfg_ovs = 3'd4; cfg_dbits = 2'd2; cfg_par = 2'd1;
      send(9'h1C3, 9, 1, 0, 0, -1, 0);
      pop_check(9'h1C3, 0, 0, "R2 R13 off-mode 9E1");

      // R7: inverted line
      cfg_ovs = 3'd1; cfg_dbits = 2'd1; cfg_par = 2'd0;
      set_inv(1'b1);
      send(9'h081, 8, 0, 0, 0, -1, 0);
      pop_check(9'h081, 0, 0, "R7 inverted line");
      set_inv(1'b0);

      // R10: underflow
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(rx_uflow == 1'b1, "R10 uflow pulse", rx_uflow, 1);
      chk(rx_count == 3'd0, "R10 count unchanged", rx_count, 0);
      @(negedge clk);
      chk(rx_uflow == 1'b0, "R10 uflow one cycle", rx_uflow, 0);

      // R9 level, R8 overflow and order
      cfg_ovs = 3'd3; cfg_wm = 2'd2;
      send(9'h011, 8, 0, 0, 0, -1, 0);
      send(9'h022, 8, 0, 0, 0, -1, 0);
      chk(rx_level == 1'b0, "R9 below watermark", rx_level, 0);
      send(9'h033, 8, 0, 0, 0, -1, 0);
      chk(rx_level == 1'b1, "R9 at watermark", rx_level, 1);
      send(9'h044, 8, 0, 0, 0, -1, 0);
      send(9'h055, 8, 0, 0, 0, -1, 0);
      chk(rx_count == 3'd4, "R8 full holds four", rx_count, 4);
      pop_check(9'h011, 0, 0, "R8 order 1");
      pop_check(9'h022, 0, 0, "R8 order 2");
      pop_check(9'h033, 0, 0, "R8 order 3");
      pop_check(9'h044, 0, 0, "R8 order 4, fifth dropped");
      chk(rx_empty == 1'b1, "R8 empty after drain", rx_empty, 1);
      cfg_wm = 2'd3;

      // R11 R12: blocking with a start value
      cfg_sframe = 9'h05A;
      pulse_blk(1'b1);
      chk(rx_blocked == 1'b1, "R11 blocked", rx_blocked, 1);
      send(9'h011, 8, 0, 0, 0, -1, 0);
      chk(rx_count == 3'd0, "R11 frame discarded", rx_count, 0);
      send(9'h05A, 8, 0, 0, 0, -1, 0);
      chk(rx_blocked == 1'b0, "R12 match releases", rx_blocked, 0);
      send(9'h022, 8, 0, 0, 0, -1, 0);
      pop_check(9'h05A, 0, 0, "R12 start frame kept");
      pop_check(9'h022, 0, 0, "R12 later frame kept");
      cfg_sframe = 9'h000;
      pulse_blk(1'b1);
      send(9'h000, 8, 0, 0, 0, -1, 0);
      chk(rx_blocked == 1'b1 && rx_count == 3'd0, "R12 zero value never releases", rx_count, 0);
      pulse_blk(1'b0);
      chk(rx_blocked == 1'b0, "R11 clear leaves blocking", rx_blocked, 0);

      // random frames
      for (int k = 0; k < 24; k++) begin
         int nd, par, ev;
         logic [8:0] d;
         bit bp, gl;
         cfg_ovs     = 3'($urandom % 5);
         cfg_dbits   = 2'($urandom % 3);
         cfg_par     = 2'($urandom % 3);
         cfg_vote_en = 1'($urandom % 2);
         nd  = 7 + cfg_dbits;
         par = cfg_par;
         d   = 9'($urandom) & mask_of(nd);
         bp  = (par != 0) && ($urandom % 4 == 0);
         gl  = cfg_vote_en && cfg_ovs <= 3'd2 && ($urandom % 2 == 0);
         ev  = ratio_of(cfg_ovs) / 2;
         if (($urandom % 3) == 0) set_inv(!cfg_inv);
         send(d, nd, par, bp, 0, gl ? 1 + int'($urandom % nd) : -1, ev);
         pop_check(d, bp, 0, "R1 R2 R3 R5 R6 random frame");
      end
      set_inv(1'b0);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule